// File: doc/BRIEF.md
# Montgomery Modular Exponentiation Engine

This block computes `base^exponent mod modulus` for unsigned operands of a parameterized width `W` (64 bits by default, and the structure carries unchanged to 512 bits). A host loads all four operands over one shared data bus: base, modulus, exponent, and the residuum `2^(2W) mod modulus`. The residuum is computed off-block and is what the engine uses to move values into the Montgomery domain. A 3-bit command code, qualified by a valid strobe, selects which operand register the bus writes or which action runs.

Internally, a single bit-serial Montgomery multiplier computes `a*b*2^(-W) mod M` in `W` step cycles plus one reduction cycle. A small phase sequencer reuses it for every step:
- conversion of one and of the base into Montgomery form,
- a left-to-right square-and-multiply pass over all exponent bits,
- a final multiply by one that returns the result to the normal domain.

When the result is valid the engine raises `ready_o` and holds the result on `res_o`. A show command keeps it there. A prepare command reopens the loading state, and the operand registers keep their values, so a later run may reload only the operands that change.

Top module: `mont_modexp`

## Requirements
- R1: While reset is held and directly after it, `ready_o` is 0 and `res_o` is all zeros.
- R2: With `valid_i` high in the loading state, codes 001, 010, 011 and 100 capture `data_i` into base, modulus, exponent and residuum. With `valid_i` low, no code has any effect.
- R3: Code 101 with `valid_i` high in the loading state starts a run. When `ready_o` rises, `res_o` equals `base^exponent mod modulus`, provided the modulus is odd and greater than 1, the base is below the modulus, and the residuum equals `2^(2W) mod modulus`.
- R4: `ready_o` is 0 from the cycle after a start is accepted until the run completes. It is then 1.
- R5: An exponent of 0 yields 1. An exponent of 1 yields the base. Leading zero bits in the exponent do not change the result.
- R6: A base of 0 yields 0 for a nonzero exponent. A base of `modulus-1` raised to an even exponent yields 1.
- R7: Code 111 is ignored in every state. Every command received while a run is in progress is ignored, and the result of that run is unchanged.
- R8: After completion, load and start codes are ignored until code 000 returns the engine to the loading state. Operand registers keep their values across runs.
- R9: Code 110 after completion keeps `ready_o` at 1 and `res_o` unchanged.
- R10: The result is correct for the largest odd modulus `2^W-1`. This requires the multiplier accumulator to be two bits wider than the operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| data_i | input | W | Shared operand bus |
| cmd_i | input | 3 | Command code (000 prepare, 001 base, 010 modulus, 011 exponent, 100 residuum, 101 start, 110 show, 111 none) |
| valid_i | input | 1 | Qualifies `cmd_i` and `data_i` |
| ready_o | output | 1 | Result valid |
| res_o | output | W | Exponentiation result |

## Verification
The bench targets the following corner cases:
- **Modulus `2^W-1`.** A multiplier accumulator that is only one bit wider than the operands overflows on this modulus and returns a wrong value.
- **Exponent 0 and exponent 1.** These expose an engine that seeds its accumulator with plain 1 instead of the Montgomery-form one, or that skips the final conversion back to the normal domain.
- **Base of zero and base of `modulus-1`.** These catch a missing or doubled final subtraction.
- **Commands the engine must ignore.** The bench sends load and prepare codes during a run, loads after completion, code 111, and commands with `valid_i` low. The next result then shows whether any of them corrupted an operand or restarted the sequencer.

// File: rtl/mont_modexp.sv
module mont_modexp #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] data_i,
  input  logic [2:0]   cmd_i,
  input  logic         valid_i,
  output logic         ready_o,
  output logic [W-1:0] res_o
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);
  localparam logic [W-1:0] ONE = W'(1);

  typedef enum logic [2:0] {S_LOAD, S_RUN, S_FIN, S_DONE, S_SHOW} st_t;
  typedef enum logic [2:0] {P_ONE, P_BASE, P_SQ, P_MUL, P_OUT} ph_t;

  st_t state;
  ph_t phase;
  logic [W-1:0] base_q, mod_q, exp_q, rsd_q, acc_q, bm_q, res_q, mx, my;
  logic [W+1:0] pacc;
  logic [CW-1:0] cnt, bi;
  logic ready_q;

  wire [W+1:0] m2   = {2'b00, mod_q};
  wire [W+1:0] t1   = pacc + (mx[0] ? {2'b00, my} : '0);
  wire [W+1:0] t2   = t1 + (t1[0] ? m2 : '0);
  wire [W+1:0] diff = pacc - m2;
  wire [W-1:0] fin  = (pacc >= m2) ? diff[W-1:0] : pacc[W-1:0];

  assign ready_o = ready_q;
  assign res_o   = res_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_LOAD; phase <= P_ONE;
      base_q <= '0; mod_q <= '0; exp_q <= '0; rsd_q <= '0;
      acc_q <= '0; bm_q <= '0; res_q <= '0; mx <= '0; my <= '0;
      pacc <= '0; cnt <= '0; bi <= '0; ready_q <= 1'b0;
    end else begin
      case (state)
        S_LOAD: if (valid_i) begin
          case (cmd_i)
            3'b001: base_q <= data_i;
            3'b010: mod_q  <= data_i;
            3'b011: exp_q  <= data_i;
            3'b100: rsd_q  <= data_i;
            3'b101: begin
              ready_q <= 1'b0;
              mx <= ONE; my <= rsd_q;
              pacc <= '0; cnt <= '0;
              phase <= P_ONE; state <= S_RUN;
            end
            default: ;
          endcase
        end
        S_RUN: begin
          pacc <= t2 >> 1;
          mx <= mx >> 1;
          cnt <= cnt + 1'b1;
          if (cnt == LAST) state <= S_FIN;
        end
        S_FIN: begin
          pacc <= '0; cnt <= '0; state <= S_RUN;
          case (phase)
            P_ONE: begin
              acc_q <= fin; mx <= base_q; my <= rsd_q; phase <= P_BASE;
            end
            P_BASE: begin
              bm_q <= fin; mx <= acc_q; my <= acc_q; bi <= LAST; phase <= P_SQ;
            end
            P_SQ: begin
              acc_q <= fin; mx <= fin;
              if (exp_q[bi]) begin
                my <= bm_q; phase <= P_MUL;
              end else if (bi == '0) begin
                my <= ONE; phase <= P_OUT;
              end else begin
                my <= fin; bi <= bi - 1'b1;
              end
            end
            P_MUL: begin
              acc_q <= fin; mx <= fin;
              if (bi == '0) begin
                my <= ONE; phase <= P_OUT;
              end else begin
                my <= fin; bi <= bi - 1'b1; phase <= P_SQ;
              end
            end
            default: begin
              res_q <= fin; ready_q <= 1'b1; state <= S_DONE;
            end
          endcase
        end
        S_DONE: if (valid_i && cmd_i == 3'b110) state <= S_SHOW;
                else if (valid_i && cmd_i == 3'b000) state <= S_LOAD;
        default: if (valid_i && cmd_i == 3'b000) state <= S_LOAD;
      endcase
    end
  end

  // R10: accumulator stays below 2M during the multiply steps
  p_acc_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RUN) |-> (pacc < {1'b0, mod_q, 1'b0}));

  // R3: reduced product is below the modulus
  p_fin_reduced_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FIN) |-> (fin < mod_q));

  p_start_clears_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_LOAD && valid_i && cmd_i == 3'b101) |=> !ready_o);

  p_busy_not_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RUN) |-> !ready_o);

  p_result_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SHOW) |=> ($stable(res_o) && ready_o));

  p_operands_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DONE || state == S_SHOW) |=> ($stable(base_q) && $stable(exp_q) && $stable(mod_q)));
endmodule

// File: tb/mont_modexp_tb.sv
module mont_modexp_tb;
  localparam int W = 64;
  localparam time TCLK = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] data_i = '0;
  logic [2:0] cmd_i = 3'b111;
  logic valid_i = 1'b0;
  logic ready_o;
  logic [W-1:0] res_o;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [W-1:0] exp_q[$];
  string tag_q[$];
  logic prev_rdy = 1'b0;

  always #(TCLK/2) clk = ~clk;

  mont_modexp #(.W(W)) u_dut (.clk, .rst_n, .data_i, .cmd_i, .valid_i, .ready_o, .res_o);

  function automatic logic [W-1:0] ref_exp(logic [W-1:0] b, logic [W-1:0] e, logic [W-1:0] m);
    logic [127:0] r, bb, mm;
    mm = {64'd0, m}; bb = {64'd0, b} % mm; r = 128'd1 % mm;
    for (int i = W - 1; i >= 0; i--) begin
      r = (r * r) % mm;
      if (e[i]) r = (r * bb) % mm;
    end
    return r[W-1:0];
  endfunction

  function automatic logic [W-1:0] ref_rsd(logic [W-1:0] m);
    logic [127:0] x, mm;
    mm = {64'd0, m}; x = 128'd1 % mm;
    for (int i = 0; i < 2 * W; i++) x = (x << 1) % mm;
    return x[W-1:0];
  endfunction

  task automatic check(bit ok, string tag, logic [W-1:0] act, logic [W-1:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic drive(logic [2:0] c, logic [W-1:0] d, bit v);
    @(negedge clk);
    cmd_i = c; data_i = d; valid_i = v;
    @(negedge clk);
  endtask

  task automatic load_all(logic [W-1:0] b, logic [W-1:0] e, logic [W-1:0] m);
    drive(3'b001, b, 1);
    drive(3'b010, m, 1);
    drive(3'b011, e, 1);
    drive(3'b100, ref_rsd(m), 1);
  endtask

  task automatic run(logic [W-1:0] expv, string tag, bit disturb);
    exp_q.push_back(expv); tag_q.push_back(tag);
    @(negedge clk);
    cmd_i = 3'b101; valid_i = 1'b1;
    @(negedge clk);
    check(ready_o == 1'b0, "R4 ready cleared after start", {63'd0, ready_o}, '0);
    cmd_i = 3'b111;
    if (disturb) begin
      repeat (100) @(negedge clk);
      cmd_i = 3'b001; data_i = 64'h5;
      repeat (3) @(negedge clk);
      cmd_i = 3'b000;
      repeat (3) @(negedge clk);
      cmd_i = 3'b101;
      repeat (3) @(negedge clk);
      check(ready_o == 1'b0, "R7 still busy after ignored commands", {63'd0, ready_o}, '0);
      cmd_i = 3'b111;
    end
    while (!ready_o) @(negedge clk);
    @(negedge clk);
    cmd_i = 3'b110;
    repeat (3) @(negedge clk);
    check(ready_o == 1'b1, "R9 ready held in show", {63'd0, ready_o}, 64'd1);
    check(res_o == expv, "R9 result held in show", res_o, expv);
    cmd_i = 3'b111;
  endtask

  task automatic prep();
    drive(3'b000, '0, 1);
    drive(3'b111, '0, 1);
  endtask

  always @(negedge clk) begin
    if (ready_o && !prev_rdy) begin
      if (exp_q.size() == 0) check(0, "R4 unexpected ready", res_o, '0);
      else begin
        logic [W-1:0] e;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        check(res_o == e, t, res_o, e);
      end
    end
    prev_rdy = ready_o;
  end

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  localparam logic [W-1:0] M1 = 64'hd3a1_5c97_0b2e_f44b;
  localparam logic [W-1:0] B1 = 64'h1234_5678_9abc_def0;
  localparam logic [W-1:0] E1 = 64'hfedc_ba98_7654_3211;

  initial begin
    repeat (3) @(negedge clk);
    check(ready_o == 1'b0 && res_o == '0, "R1 reset state", res_o, '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(ready_o == 1'b0 && res_o == '0, "R1 after reset", res_o, '0);

    load_all(B1, E1, M1);
    run(ref_exp(B1, E1, M1), "R3 full exponent", 0);

    drive(3'b001, 64'h7, 1);
    drive(3'b101, '0, 1);
    check(res_o == ref_exp(B1, E1, M1), "R8 load in show ignored", res_o, ref_exp(B1, E1, M1));
    prep();
    run(ref_exp(B1, E1, M1), "R8 rerun with kept operands", 0);

    prep();
    drive(3'b001, 64'h9, 0);
    drive(3'b101, '0, 0);
    check(ready_o == 1'b1, "R2 start with valid low ignored", {63'd0, ready_o}, 64'd1);
    drive(3'b111, 64'h3, 1);
    run(ref_exp(B1, E1, M1), "R2 R7 ignored codes leave operands", 0);

    prep();
    run(ref_exp(B1, E1, M1), "R7 commands during run ignored", 1);

    prep(); drive(3'b011, 64'd0, 1);
    run(64'd1, "R5 exponent zero", 0);
    prep(); drive(3'b011, 64'd1, 1);
    run(B1, "R5 exponent one", 0);
    prep(); drive(3'b011, 64'd5, 1);
    run(ref_exp(B1, 64'd5, M1), "R5 leading zeros", 0);

    prep(); drive(3'b001, 64'd0, 1); drive(3'b011, 64'd13, 1);
    run(64'd0, "R6 base zero", 0);
    prep(); drive(3'b001, M1 - 1, 1); drive(3'b011, 64'd2, 1);
    run(64'd1, "R6 base m-1 even exponent", 0);

    prep(); load_all(64'hffff_ffff_ffff_fffe, E1, 64'hffff_ffff_ffff_ffff);
    run(ref_exp(64'hffff_ffff_ffff_fffe, E1, 64'hffff_ffff_ffff_ffff), "R10 all-ones modulus", 0);

    prep(); load_all(64'd2, 64'd3, 64'd3);
    run(64'd2, "R3 small modulus", 0);

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) check(0, "R3 results missing", '0, '0);
    finish_up();
  end
endmodule